// File: doc/BRIEF.md
# Sync Field Bit Serializer

This block turns a configured synchronisation pattern into a serial bit stream for a packet transmitter. Software or a sequencer sets three pattern bytes and a 5-bit match length. A start request loads the pattern. After that the block sends one bit for each transmit bit strobe. The length selects how many bytes go on air, and the field is always a whole number of bytes. When the last bit has gone out, a single-cycle done pulse tells the payload path that it may follow.

The bytes that are sent are taken from the upper end of the pattern. They go out in order: first the least significant byte that is sent, then the next, and the upper byte last. Each byte leaves most significant bit first. When the length is not a multiple of eight, the low bits of the least significant sent byte are expected to hold preamble fill. The block sends those bits exactly as they were given.

Top module: `sync_tx_serializer`

## Requirements
- R1: Every byte is sent most significant bit first. All eight bits of each sent byte go out unchanged, and this includes preamble fill in its low bits.
- R2: A length from 17 to 31 sends 24 bits in this order: pattern low byte, then middle byte, then high byte.
- R3: A length from 8 to 16 sends 16 bits: the middle byte first, then the high byte. The low byte is never sent.
- R4: A length from 1 to 7 sends only the high byte, which is 8 bits.
- R5: A start request with length 0 gives `done_o` high in the next cycle. `busy_o` stays low, and `tx_bit_vld_o` is never raised.
- R6: `tx_bit_vld_o` is high only in a cycle where `bit_strobe_i` is high and `busy_o` is high. Each such cycle presents exactly one new bit on `tx_bit_o`.
- R7: `done_o` is high for exactly one cycle, the cycle after the last bit-valid cycle. In that same cycle `busy_o` is low.
- R8: A start request that arrives while `busy_o` is high is ignored. The current field is neither restarted nor changed.
- R9: The pattern bytes and the length are captured when a start is accepted. Changing them later has no effect on the field in flight.
- R10: After an accepted start with a nonzero length, `busy_o` is high from the next cycle on. A strobe in the start cycle itself sends no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send the sync field; accepted only while idle |
| bit_strobe_i | input | 1 | Transmit bit strobe, one bit per high cycle |
| pat_lo_i | input | 8 | Pattern low byte |
| pat_mid_i | input | 8 | Pattern middle byte |
| pat_hi_i | input | 8 | Pattern high byte |
| sync_len_i | input | 5 | Sync match length in bits (0 to 31) |
| tx_bit_o | output | 1 | Serial bit; meaningful when tx_bit_vld_o is high |
| tx_bit_vld_o | output | 1 | A bit is being sent this cycle |
| busy_o | output | 1 | Field in progress |
| done_o | output | 1 | One-cycle pulse when the field has finished |

## Verification
The assertions watch several rules on every cycle. `done_o` must be a single-cycle pulse, and each fall of `busy_o` must coincide with it. The bit counter may change only on a strobe, and a start that arrives while busy must not disturb it. A zero-length request must finish at once. The number of bit-valid cycles must equal the bit count implied by the captured length. Only the bench scenarios can show that the bit values and byte order are correct for each length range, that preamble fill passes through, and that changing the configuration in mid-field or raising start while busy leaves the serial stream unchanged.

// File: rtl/sync_ser_pkg.sv
package sync_ser_pkg;

  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 3;
  localparam int FIELD_W   = BYTE_W * NUM_BYTES;
  localparam int LEN_W     = 5;
  localparam int CNT_W     = $clog2(FIELD_W + 1);
  localparam int NB_W      = $clog2(NUM_BYTES + 1);

  // Number of whole bytes put on air for a given match length.
  // Lengths up to and including two full bytes use the two-byte form.
  function automatic logic [NB_W-1:0] bytes_for_len(input logic [LEN_W-1:0] len);
    int l;
    l = int'(len);
    if (l == 0)                 return NB_W'(0);
    else if (l > 2 * BYTE_W)    return NB_W'(3);
    else if (l >= BYTE_W)       return NB_W'(2);
    else                        return NB_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] bits_for_bytes(input logic [NB_W-1:0] nb);
    return CNT_W'(int'(nb) * BYTE_W);
  endfunction

  // Arrange the sent bytes so that the first bit on air sits at the MSB.
  // Sent bytes come from the top of the pattern; the lowest sent byte leads.
  function automatic logic [FIELD_W-1:0] load_word(input logic [FIELD_W-1:0] pat,
                                                   input logic [NB_W-1:0]    nb);
    logic [FIELD_W-1:0] w;
    int src;
    w = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (k < int'(nb)) begin
        src = NUM_BYTES - int'(nb) + k;
        w[FIELD_W-1-k*BYTE_W -: BYTE_W] = pat[src*BYTE_W +: BYTE_W];
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/sync_ser_ctrl.sv
module sync_ser_ctrl
  import sync_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             strobe,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic             load_en,
  output logic             shift_en,
  output logic [NB_W-1:0]  nbytes_now
);

  logic [CNT_W-1:0] remain;
  logic             last_bit;
  logic             zero_req;

  assign accept     = start & ~busy;
  assign nbytes_now = bytes_for_len(len);
  assign zero_req   = accept & (nbytes_now == '0);
  assign load_en    = accept & (nbytes_now != '0);
  assign shift_en   = busy & strobe;
  assign last_bit   = shift_en & (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= zero_req | last_bit;
      if (load_en) begin
        busy   <= 1'b1;
        remain <= bits_for_bytes(nbytes_now);
      end else if (last_bit) begin
        busy   <= 1'b0;
        remain <= '0;
      end else if (shift_en) begin
        remain <= remain - CNT_W'(1);
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  remain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !strobe |=> busy && $stable(remain));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !strobe |=> busy && $stable(remain));

endmodule

// File: rtl/sync_ser_shift.sv
module sync_ser_shift
  import sync_ser_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               shift_en,
  input  logic [NB_W-1:0]    nbytes,
  input  logic [FIELD_W-1:0] pattern,
  output logic               bit_out
);

  logic [FIELD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sreg <= '0;
    else if (load_en)
      sreg <= load_word(pattern, nbytes);
    else if (shift_en)
      sreg <= {sreg[FIELD_W-2:0], 1'b0};
  end

  assign bit_out = sreg[FIELD_W-1];

  // R1
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !load_en |=> bit_out == $past(sreg[FIELD_W-2]));

endmodule

// File: rtl/sync_tx_serializer.sv
module sync_tx_serializer
  import sync_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       bit_strobe_i,
  input  logic [7:0] pat_lo_i,
  input  logic [7:0] pat_mid_i,
  input  logic [7:0] pat_hi_i,
  input  logic [4:0] sync_len_i,
  output logic       tx_bit_o,
  output logic       tx_bit_vld_o,
  output logic       busy_o,
  output logic       done_o
);

  logic              accept;
  logic              load_en;
  logic              shift_en;
  logic [NB_W-1:0]   nbytes_now;
  logic [FIELD_W-1:0] pattern;

  assign pattern = {pat_hi_i, pat_mid_i, pat_lo_i};

  sync_ser_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .strobe     (bit_strobe_i),
    .len        (sync_len_i),
    .busy       (busy_o),
    .done       (done_o),
    .accept     (accept),
    .load_en    (load_en),
    .shift_en   (shift_en),
    .nbytes_now (nbytes_now)
  );

  sync_ser_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .shift_en (shift_en),
    .nbytes   (nbytes_now),
    .pattern  (pattern),
    .bit_out  (tx_bit_o)
  );

  assign tx_bit_vld_o = shift_en;

  // Checker state: bits seen since the last accepted start, and the total expected.
  logic [CNT_W-1:0] sent_cnt;
  logic [CNT_W-1:0] exp_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_cnt <= '0;
      exp_bits <= '0;
    end else if (accept) begin
      sent_cnt <= '0;
      exp_bits <= CNT_W'(int'(bytes_for_len(sync_len_i)) * BYTE_W);
    end else if (tx_bit_vld_o) begin
      sent_cnt <= sent_cnt + CNT_W'(1);
    end
  end

  // R2
  bit_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> sent_cnt == exp_bits);

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && sync_len_i == '0 |=> done_o && !busy_o);

  // R7
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: tb/tb_sync_tx_serializer.sv
`timescale 1ns/1ps
module tb_sync_tx_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       bit_strobe_i = 1'b0;
  logic [7:0] pat_lo_i = '0, pat_mid_i = '0, pat_hi_i = '0;
  logic [4:0] sync_len_i = '0;
  logic       tx_bit_o, tx_bit_vld_o, busy_o, done_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";
  bit    exp_q[$];

  always #10 clk = ~clk;

  sync_tx_serializer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_strobe_i(bit_strobe_i),
    .pat_lo_i(pat_lo_i), .pat_mid_i(pat_mid_i), .pat_hi_i(pat_hi_i),
    .sync_len_i(sync_len_i), .tx_bit_o(tx_bit_o), .tx_bit_vld_o(tx_bit_vld_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected bit per valid cycle.
  always @(negedge clk) begin
    if (rst_n && tx_bit_vld_o) begin
      // R6: valid only with a strobe
      chk(bit_strobe_i == 1'b1, "R6 valid without strobe", 1, 0);
      if (exp_q.size() == 0)
        chk(1'b0, {cur_req, " unexpected bit"}, int'(tx_bit_o), -1);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(tx_bit_o == e, {cur_req, " bit value"}, int'(tx_bit_o), int'(e));
      end
    end
  end

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
  endtask

  // Driver: pushes the expected stream, then runs one field.
  task automatic run_field(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] hi,
                           input logic [4:0] len, input int gap, input bit strobe_at_start,
                           input bit mutate, input bit restart_mid, input string req);
    int nbits;
    cur_req = req;
    if (len > 16)      begin push_byte(lo); push_byte(mid); push_byte(hi); end
    else if (len >= 8) begin push_byte(mid); push_byte(hi); end
    else if (len >= 1) begin push_byte(hi); end
    nbits = exp_q.size();

    @(posedge clk); #1;
    start_i = 1'b1; bit_strobe_i = strobe_at_start;
    pat_lo_i = lo; pat_mid_i = mid; pat_hi_i = hi; sync_len_i = len;
    @(posedge clk); #1;
    start_i = 1'b0; bit_strobe_i = 1'b0;
    if (mutate) begin
      pat_lo_i = ~lo; pat_mid_i = ~mid; pat_hi_i = ~hi; sync_len_i = 5'd3;
    end
    @(negedge clk);
    if (nbits == 0) begin
      chk(done_o && !busy_o, {req, " zero-length done"}, int'({done_o, busy_o}), 2);
      @(posedge clk); #1;
      @(negedge clk);
      chk(!done_o && !busy_o, {req, " zero-length quiet"}, int'({done_o, busy_o}), 0);
      return;
    end
    chk(busy_o && !done_o, "R10 busy after start", int'(busy_o), 1);
    chk(exp_q.size() == nbits, "R10 no bit in start cycle", exp_q.size(), nbits);

    for (int i = 0; i < nbits; i++) begin
      @(posedge clk); #1;
      bit_strobe_i = 1'b1;
      if (restart_mid && i == 2) begin
        start_i = 1'b1; sync_len_i = 5'd24; pat_lo_i = 8'h00; pat_mid_i = 8'h00; pat_hi_i = 8'h00;
      end
      @(posedge clk); #1;
      bit_strobe_i = 1'b0; start_i = 1'b0;
      @(negedge clk);
      if (i == nbits - 1)
        chk(done_o && !busy_o, "R7 done after last bit", int'({done_o, busy_o}), 2);
      else if (i == 0 || i == nbits - 2)
        chk(busy_o && !done_o, "R7 busy during field", int'({done_o, busy_o}), 1);
      repeat (gap) @(posedge clk);
    end
    @(negedge clk);
    chk(!done_o, "R7 done single cycle", int'(done_o), 0);
    chk(exp_q.size() == 0, {req, " all bits sent"}, exp_q.size(), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !tx_bit_vld_o, "R5 reset state",
        int'({busy_o, done_o, tx_bit_vld_o}), 0);

    run_field(8'hA5, 8'h3C, 8'h96, 5'd24, 0, 1'b0, 1'b0, 1'b0, "R2 len24");
    run_field(8'h81, 8'h7E, 8'h18, 5'd17, 2, 1'b0, 1'b0, 1'b0, "R2 len17");
    run_field(8'hF0, 8'h0F, 8'hC3, 5'd31, 1, 1'b0, 1'b0, 1'b0, "R2 len31");
    run_field(8'hFF, 8'hD2, 8'h4B, 5'd16, 0, 1'b0, 1'b0, 1'b0, "R3 len16");
    run_field(8'hFF, 8'h55, 8'hAA, 5'd8,  3, 1'b0, 1'b0, 1'b0, "R3 len8");
    run_field(8'h00, 8'hB5, 8'h6E, 5'd12, 0, 1'b0, 1'b0, 1'b0, "R1 fill len12");
    run_field(8'hFF, 8'hFF, 8'h9A, 5'd7,  0, 1'b0, 1'b0, 1'b0, "R4 len7");
    run_field(8'h00, 8'h00, 8'h80, 5'd1,  1, 1'b0, 1'b0, 1'b0, "R4 len1");
    run_field(8'h12, 8'h34, 8'h56, 5'd0,  0, 1'b0, 1'b0, 1'b0, "R5 len0");
    run_field(8'hC6, 8'h39, 8'hE1, 5'd20, 0, 1'b1, 1'b0, 1'b0, "R10 strobe at start");
    run_field(8'h5A, 8'hA5, 8'h3E, 5'd18, 1, 1'b0, 1'b1, 1'b0, "R9 config change");
    run_field(8'h77, 8'h1D, 8'hB2, 5'd10, 0, 1'b0, 1'b0, 1'b1, "R8 start while busy");

    // R6: idle strobes produce no valid bits
    @(posedge clk); #1 bit_strobe_i = 1'b1;
    @(negedge clk);
    chk(!tx_bit_vld_o, "R6 idle strobe", int'(tx_bit_vld_o), 0);
    @(posedge clk); #1 bit_strobe_i = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule